// File: doc/BRIEF.md
# I2C Master Register Front End

This block is the byte-wide register window that software uses to drive an I2C master. Software loads a slave address, a data byte and a control word. The block turns data-register writes, control-register writes and data-register reads into short sequences of byte-level commands for a bus engine. Those commands are start-for-write, start-for-read, send, receive and stop. Progress and failures are reported in a status register and an extended-status register. Bit-level bus signalling belongs to the engine and lies outside this block.

The CPU side uses a valid/ready handshake. An access completes in the cycle where `cpu_valid` and `cpu_ready` are both high. The CPU must hold `cpu_write`, `cpu_addr` and `cpu_wdata` stable while `cpu_ready` is low. Plain register accesses complete in their first cycle. An access that needs the bus holds `cpu_ready` low until its whole command sequence has finished. A register write takes effect in the first cycle the access is presented. Read data is valid in the completing cycle.

The engine side also uses valid/ready. `eng_cmd_valid` stays high with a stable opcode and data until `eng_cmd_ready` is seen. The engine then reports the result with a one-cycle `eng_done`, together with `eng_ack` and, after a receive, `eng_rdata`. Only one command is outstanding at any time.

Top module: `i2cr_top`

## Requirements
- R1: After reset, status, extended status, control, mode, address, data, count and extended control read 0x00, and the direct-line register reads 0x0F.
- R2: Offsets are data 0x00, address 0x01, control 0x02, mode 0x03, status 0x04, extended status 0x05, count 0x06, extended control 0x07 and direct-line 0x08. Writes store the value ANDed with a mask: 0xDF for mode, 0x77 for count and 0x07 for direct-line. Address, control, data and extended control (without bit 0 set) are stored whole.
- R3: A status write clears only the bits set in both the value and 0x0A, so busy (bit 0), error (bit 2) and read-data-ready (bit 5) survive it. An extended-status write clears the bits set in both the value and 0x8F.
- R4: Offsets 0x09 and above read 0x00, and writes to them change no register.
- R5: Opcodes are start-write 0, start-read 1, send 2, receive 3 and stop 4. The engine address is address-register bits 7:1. When the bus is idle, a data write issues start-write and then send of the byte. An acked start sets busy and clears error.
- R6: When the bus is held, a data write issues only send. A NACK on the send issues stop, clears busy, sets error and sets the aborted flag (extended-status bit 0), and it releases the bus.
- R7: A NACK on start-write clears busy, sets error and the aborted flag, and issues no send.
- R8: A control write with bit 0 (go) and bit 1 (read) set clears busy, then issues stop if the bus is held, then issues start-read. An ack sets read-data-ready and clears error. A NACK clears busy and sets error and the aborted flag.
- R9: A control write with go set and read clear clears busy and issues no command.
- R10: A data read while read-data-ready is clear issues no command and returns the stored data byte.
- R11: A data read while read-data-ready is set and the pending field (control bits 5:4) is zero issues receive, returns the received byte and clears read-data-ready.
- R12: With a nonzero pending field, a data read issues receive, stop and start-read, returns the byte, writes the pending field minus one back into control bits 5:4, and leaves read-data-ready set after an acked restart.
- R13: Writing a value with bit 0 set to extended control returns every register to its reset value.
- R14: The block never has more than one engine command outstanding. A command stays valid and stable until accepted. While a command is in flight, `cpu_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU access request |
| cpu_write | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | AW | Byte offset in the window |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 8 | Read byte, valid with cpu_ready |
| eng_cmd_valid | output | 1 | Engine command request |
| eng_cmd_ready | input | 1 | Engine accepts command |
| eng_cmd_op | output | 3 | Command opcode (R5 encoding) |
| eng_cmd_addr | output | 7 | 7-bit slave address |
| eng_cmd_data | output | 8 | Byte for send |
| eng_done | input | 1 | Command finished, one-cycle pulse |
| eng_ack | input | 1 | Slave acknowledged, valid with eng_done |
| eng_rdata | input | 8 | Received byte, valid with eng_done |

## Verification
Data writes are tried with the bus idle and with the bus held, and each case is run once with an ack and once with a NACK on the start or the send. Comparing the logged command sequences shows whether a start was issued, whether a send was skipped and whether a stop followed. Data reads are tried with read-data-ready clear, with a zero pending field and with pending fields of two and one. These cases separate the no-command path, the single receive and the chained receive-stop-restart sequence with its countdown in control. One command is held back by the engine for several cycles, which shows that the command is held stable and that the CPU is stalled.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int DW = 8;

  localparam int OFS_DATA   = 0;
  localparam int OFS_ADDR   = 1;
  localparam int OFS_CTRL   = 2;
  localparam int OFS_MODE   = 3;
  localparam int OFS_STAT   = 4;
  localparam int OFS_EXT    = 5;
  localparam int OFS_XCNT   = 6;
  localparam int OFS_XTCTL  = 7;
  localparam int OFS_DIRECT = 8;

  localparam logic [DW-1:0] MODE_MASK = 8'hDF;
  localparam logic [DW-1:0] XCNT_MASK = 8'h77;
  localparam logic [DW-1:0] DIR_MASK  = 8'h07;
  localparam logic [DW-1:0] STAT_W1C  = 8'h0A;
  localparam logic [DW-1:0] EXT_W1C   = 8'h8F;

  localparam int CT_GO   = 0;
  localparam int CT_RD   = 1;
  localparam int PEND_LO = 4;
  localparam int ST_PT   = 0;
  localparam int ST_ERR  = 2;
  localparam int ST_MDBS = 5;
  localparam int EX_ABRT = 0;
  localparam int XT_SRST = 0;

  typedef enum logic [2:0] {
    OP_START_W = 3'd0,
    OP_START_R = 3'd1,
    OP_SEND    = 3'd2,
    OP_RECV    = 3'd3,
    OP_STOP    = 3'd4
  } eng_op_e;

  typedef struct packed {
    logic [DW-1:0] data;
    logic [DW-1:0] addr;
    logic [DW-1:0] ctrl;
    logic [DW-1:0] mode;
    logic [DW-1:0] stat;
    logic [DW-1:0] ext;
    logic [DW-1:0] xcnt;
    logic [DW-1:0] xtctl;
    logic [DW-1:0] direct;
  } regs_t;

  localparam regs_t REGS_RST = '{data: 8'h00, addr: 8'h00, ctrl: 8'h00,
                                 mode: 8'h00, stat: 8'h00, ext: 8'h00,
                                 xcnt: 8'h00, xtctl: 8'h00, direct: 8'h0F};

  typedef struct packed {
    logic wr_ok;
    logic nack;
    logic pt_clr;
    logic rd_ok;
    logic mdbs_clr;
    logic rx_load;
    logic pend_load;
  } hw_ev_t;
endpackage

// File: rtl/i2cr_regfile.sv
module i2cr_regfile
  import i2cr_pkg::*;
#(
  parameter int AW     = 5,
  parameter int WINDOW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  hw_ev_t        ev,
  input  logic [DW-1:0] rx_byte,
  input  logic [1:0]    pend_next,
  output logic [DW-1:0] rd_data,
  output regs_t         regs
);
  regs_t regs_q;
  logic  wr_win, rd_win, srst;

  assign wr_win = int'(wr_addr) < WINDOW;
  assign rd_win = int'(rd_addr) < WINDOW;
  assign srst   = wr_en && wr_win && (wr_addr == AW'(OFS_XTCTL)) && wr_data[XT_SRST];
  assign regs   = regs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= REGS_RST;
    end else if (srst) begin
      regs_q <= REGS_RST;
    end else begin
      if (wr_en && wr_win) begin
        case (wr_addr)
          AW'(OFS_DATA):   regs_q.data   <= wr_data;
          AW'(OFS_ADDR):   regs_q.addr   <= wr_data;
          AW'(OFS_CTRL):   regs_q.ctrl   <= wr_data;
          AW'(OFS_MODE):   regs_q.mode   <= wr_data & MODE_MASK;
          AW'(OFS_STAT):   regs_q.stat   <= regs_q.stat & ~(wr_data & STAT_W1C);
          AW'(OFS_EXT):    regs_q.ext    <= regs_q.ext & ~(wr_data & EXT_W1C);
          AW'(OFS_XCNT):   regs_q.xcnt   <= wr_data & XCNT_MASK;
          AW'(OFS_XTCTL):  regs_q.xtctl  <= wr_data;
          AW'(OFS_DIRECT): regs_q.direct <= wr_data & DIR_MASK;
          default: ;
        endcase
      end
      if (ev.wr_ok) begin
        regs_q.stat[ST_PT]  <= 1'b1;
        regs_q.stat[ST_ERR] <= 1'b0;
      end
      if (ev.nack) begin
        regs_q.stat[ST_PT]   <= 1'b0;
        regs_q.stat[ST_ERR]  <= 1'b1;
        regs_q.ext[EX_ABRT]  <= 1'b1;
      end
      if (ev.pt_clr)    regs_q.stat[ST_PT]   <= 1'b0;
      if (ev.rd_ok) begin
        regs_q.stat[ST_MDBS] <= 1'b1;
        regs_q.stat[ST_ERR]  <= 1'b0;
      end
      if (ev.mdbs_clr)  regs_q.stat[ST_MDBS] <= 1'b0;
      if (ev.rx_load)   regs_q.data          <= rx_byte;
      if (ev.pend_load) regs_q.ctrl[PEND_LO+:2] <= pend_next;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_win) begin
      case (rd_addr)
        AW'(OFS_DATA):   rd_data = regs_q.data;
        AW'(OFS_ADDR):   rd_data = regs_q.addr;
        AW'(OFS_CTRL):   rd_data = regs_q.ctrl;
        AW'(OFS_MODE):   rd_data = regs_q.mode;
        AW'(OFS_STAT):   rd_data = regs_q.stat;
        AW'(OFS_EXT):    rd_data = regs_q.ext;
        AW'(OFS_XCNT):   rd_data = regs_q.xcnt;
        AW'(OFS_XTCTL):  rd_data = regs_q.xtctl;
        AW'(OFS_DIRECT): rd_data = regs_q.direct;
        default:         rd_data = '0;
      endcase
    end
  end

  AST_DIRECT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_win && wr_addr == AW'(OFS_DIRECT)) |=> (regs_q.direct[7:3] == 5'd0)); // R2
  AST_STAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_win && wr_addr == AW'(OFS_STAT) && ev == '0) |=>
      ($stable(regs_q.stat[ST_PT]) && $stable(regs_q.stat[ST_ERR]) && $stable(regs_q.stat[ST_MDBS]))); // R3
  AST_ABORT_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(regs_q.ext[EX_ABRT]) |-> (regs_q.stat[ST_ERR] && !regs_q.stat[ST_PT])); // R7
  AST_SRST_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (regs_q.direct == 8'h0F && regs_q.ctrl == 8'h00)); // R13
endmodule

// File: rtl/i2cr_cmd_port.sv
module i2cr_cmd_port
  import i2cr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  eng_op_e       op_in,
  input  logic [DW-1:0] data_in,
  input  logic          eng_cmd_ready,
  input  logic          eng_done,
  input  logic          eng_ack,
  input  logic [DW-1:0] eng_rdata,
  output logic          eng_cmd_valid,
  output eng_op_e       eng_cmd_op,
  output logic [DW-1:0] eng_cmd_data,
  output logic          fin,
  output logic          fin_ack,
  output logic [DW-1:0] fin_byte
);
  typedef enum logic [1:0] {P_IDLE, P_ISSUE, P_WAIT} phase_e;
  phase_e  ph;
  eng_op_e op_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= P_IDLE;
      op_q   <= OP_STOP;
      data_q <= '0;
    end else begin
      case (ph)
        P_IDLE:  if (go) begin
                   ph     <= P_ISSUE;
                   op_q   <= op_in;
                   data_q <= data_in;
                 end
        P_ISSUE: if (eng_cmd_ready) ph <= P_WAIT;
        P_WAIT:  if (eng_done) ph <= P_IDLE;
        default: ph <= P_IDLE;
      endcase
    end
  end

  assign eng_cmd_valid = (ph == P_ISSUE);
  assign eng_cmd_op    = op_q;
  assign eng_cmd_data  = data_q;
  assign fin           = (ph == P_WAIT) && eng_done;
  assign fin_ack       = eng_ack;
  assign fin_byte      = eng_rdata;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd_valid && !eng_cmd_ready) |=>
      (eng_cmd_valid && $stable(eng_cmd_op) && $stable(eng_cmd_data))); // R14
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (ph == P_IDLE)); // R14
endmodule

// File: rtl/i2cr_top.sv
module i2cr_top
  import i2cr_pkg::*;
#(
  parameter int AW     = 5,
  parameter int WINDOW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic          cpu_write,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic          cpu_ready,
  output logic [7:0]    cpu_rdata,
  output logic          eng_cmd_valid,
  input  logic          eng_cmd_ready,
  output logic [2:0]    eng_cmd_op,
  output logic [6:0]    eng_cmd_addr,
  output logic [7:0]    eng_cmd_data,
  input  logic          eng_done,
  input  logic          eng_ack,
  input  logic [7:0]    eng_rdata
);
  typedef enum logic [3:0] {
    S_IDLE, S_WSTART, S_WSEND, S_NSTOP, S_RSTOP, S_RSTART, S_RECV, S_DONE
  } seq_e;

  seq_e    st, st_n;
  logic    busy, busy_n, go_q, go_n;
  hw_ev_t  ev;
  regs_t   regs;
  eng_op_e op_sel, op_out;
  logic    fin, fin_ack;
  logic [DW-1:0] fin_byte;
  logic    wr_en, need_eng;
  logic    is_wr_data, is_go_rd, is_go_wr, is_rd_data;
  logic [1:0] pend_cur, pend_next;

  assign is_wr_data = cpu_write && cpu_addr == AW'(OFS_DATA);
  assign is_go_rd   = cpu_write && cpu_addr == AW'(OFS_CTRL) && cpu_wdata[CT_GO] && cpu_wdata[CT_RD];
  assign is_go_wr   = cpu_write && cpu_addr == AW'(OFS_CTRL) && cpu_wdata[CT_GO] && !cpu_wdata[CT_RD];
  assign is_rd_data = !cpu_write && cpu_addr == AW'(OFS_DATA) && regs.stat[ST_MDBS];
  assign need_eng   = is_wr_data || is_go_rd || is_rd_data;
  assign wr_en      = (st == S_IDLE) && cpu_valid && cpu_write;
  assign cpu_ready  = ((st == S_IDLE) && !need_eng) || (st == S_DONE);
  assign pend_cur   = regs.ctrl[PEND_LO+:2];
  assign pend_next  = pend_cur - 2'd1;

  always_comb begin
    st_n   = st;
    busy_n = busy;
    ev     = '0;
    case (st)
      S_IDLE: if (cpu_valid) begin
        if (is_go_wr || (is_go_rd && busy)) ev.pt_clr = 1'b1;
        if (is_wr_data)      st_n = busy ? S_WSEND : S_WSTART;
        else if (is_go_rd)   st_n = busy ? S_RSTOP : S_RSTART;
        else if (is_rd_data) st_n = S_RECV;
      end
      S_WSTART: if (fin) begin
        if (fin_ack) begin
          ev.wr_ok = 1'b1;
          busy_n   = 1'b1;
          st_n     = S_WSEND;
        end else begin
          ev.nack = 1'b1;
          st_n    = S_DONE;
        end
      end
      S_WSEND: if (fin) begin
        if (fin_ack) st_n = S_DONE;
        else begin
          ev.nack = 1'b1;
          st_n    = S_NSTOP;
        end
      end
      S_NSTOP: if (fin) begin
        busy_n = 1'b0;
        st_n   = S_DONE;
      end
      S_RSTOP: if (fin) begin
        busy_n = 1'b0;
        st_n   = S_RSTART;
      end
      S_RSTART: if (fin) begin
        if (fin_ack) begin
          ev.rd_ok = 1'b1;
          busy_n   = 1'b1;
        end else begin
          ev.nack = 1'b1;
          busy_n  = 1'b0;
        end
        st_n = S_DONE;
      end
      S_RECV: if (fin) begin
        ev.rx_load = 1'b1;
        if (pend_cur == 2'd0) begin
          ev.mdbs_clr = 1'b1;
          st_n        = S_DONE;
        end else begin
          ev.pend_load = 1'b1;
          st_n         = S_RSTOP;
        end
      end
      S_DONE:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  assign go_n = (st_n != st) && (st_n != S_IDLE) && (st_n != S_DONE);

  always_comb begin
    case (st)
      S_WSTART: op_sel = OP_START_W;
      S_WSEND:  op_sel = OP_SEND;
      S_RSTART: op_sel = OP_START_R;
      S_RECV:   op_sel = OP_RECV;
      default:  op_sel = OP_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      busy <= 1'b0;
      go_q <= 1'b0;
    end else begin
      st   <= st_n;
      busy <= busy_n;
      go_q <= go_n;
    end
  end

  i2cr_regfile #(.AW(AW), .WINDOW(WINDOW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (cpu_addr),
    .wr_data   (cpu_wdata),
    .rd_addr   (cpu_addr),
    .ev        (ev),
    .rx_byte   (fin_byte),
    .pend_next (pend_next),
    .rd_data   (cpu_rdata),
    .regs      (regs)
  );

  i2cr_cmd_port u_port (
    .clk           (clk),
    .rst_n         (rst_n),
    .go            (go_q),
    .op_in         (op_sel),
    .data_in       (regs.data),
    .eng_cmd_ready (eng_cmd_ready),
    .eng_done      (eng_done),
    .eng_ack       (eng_ack),
    .eng_rdata     (eng_rdata),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_cmd_op    (op_out),
    .eng_cmd_data  (eng_cmd_data),
    .fin           (fin),
    .fin_ack       (fin_ack),
    .fin_byte      (fin_byte)
  );

  assign eng_cmd_op   = op_out;
  assign eng_cmd_addr = regs.addr[7:1];

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && int'(cpu_addr) >= WINDOW) |-> (cpu_rdata == 8'h00)); // R4
  AST_CMD_STALLS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid |-> !cpu_ready); // R14
  AST_EMPTY_READ_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cpu_valid && !cpu_write && cpu_addr == AW'(OFS_DATA) && !regs.stat[ST_MDBS])
      |=> !eng_cmd_valid); // R10
  AST_GO_WRITE_CLEARS_PT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cpu_valid && is_go_wr) |=> !regs.stat[ST_PT]); // R9
endmodule

// File: tb/sim_i2cr_top.sv
`timescale 1ns/1ps
module sim_i2cr_top;
  localparam int OPW = 0, OPR = 1, SND = 2, RCV = 3, STP = 4;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [4:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [7:0] cpu_rdata;
  logic eng_cmd_valid;
  logic eng_cmd_ready = 1'b1;
  logic [2:0] eng_cmd_op;
  logic [6:0] eng_cmd_addr;
  logic [7:0] eng_cmd_data;
  logic eng_done = 1'b0, eng_ack = 1'b0;
  logic [7:0] eng_rdata = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  int nack_op = 7;
  int stall = 0, stall_seen = 0, stall_bad = 0, overlap = 0;
  int cnt = 0, cur_op = 0;
  logic [7:0] rx_next = 8'h9A;
  int n_log = 0;
  logic [3:0] log_op [0:2];
  logic [7:0] log_dat [0:2];
  logic [6:0] log_adr [0:2];

  always #4 clk = ~clk;

  i2cr_top u0 (.*);

  // behavioural bus engine: decisions at the falling edge
  initial begin
    for (int i = 0; i < 3; i++) log_op[i] = 4'hF;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          eng_done = 1'b1;
          eng_ack  = (cur_op != nack_op);
          eng_rdata = (cur_op == RCV) ? rx_next : 8'h00;
          if (cur_op == RCV) rx_next = rx_next + 8'd1;
        end
      end
      if (eng_cmd_valid) begin
        if (stall > 0) begin
          stall--;
          eng_cmd_ready = 1'b0;
          stall_seen++;
          if (cpu_ready) stall_bad++;
        end else begin
          eng_cmd_ready = 1'b1;
          if (cnt > 0) overlap++;
          cur_op = int'(eng_cmd_op);
          if (n_log < 3) begin
            log_op[n_log]  = 4'(eng_cmd_op);
            log_dat[n_log] = eng_cmd_data;
            log_adr[n_log] = eng_cmd_addr;
          end
          n_log++;
          cnt = 2;
        end
      end else begin
        eng_cmd_ready = 1'b1;
      end
    end
  end

  task automatic clr_log();
    n_log = 0;
    for (int i = 0; i < 3; i++) log_op[i] = 4'hF;
  endtask

  function automatic logic [31:0] sig_now();
    return {4'(n_log), log_op[0], log_op[1], log_op[2], 16'h0};
  endfunction

  function automatic logic [31:0] seq(int n, int a = 15, int b = 15, int c = 15);
    return {4'(n), 4'(a), 4'(b), 4'(c), 16'h0};
  endfunction

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cpu(input bit we, input logic [4:0] a, input logic [7:0] wd,
                     output logic [7:0] rd, output int waits);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = we; cpu_addr = a; cpu_wdata = wd;
    waits = 0;
    #1;
    while (!cpu_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    rd = cpu_rdata;
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] r; int w;
    cpu(1'b1, a, d, r, w);
  endtask

  task automatic rd_chk(input int req, input string what, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] r; int w;
    cpu(1'b0, a, 8'h00, r, w);
    check(req, what, {24'h0, r}, {24'h0, exp});
  endtask

  // vector: {write, offset, wdata, expected readback, requirement}
  typedef struct packed { logic we; logic [4:0] a; logic [7:0] wd; logic [7:0] exp; logic [3:0] req; } vec_t;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 5'h03, 8'hFF, 8'hDF, 4'd2},   // R2 mode mask
    '{1'b1, 5'h06, 8'hFF, 8'h77, 4'd2},   // R2 count mask
    '{1'b1, 5'h08, 8'hFF, 8'h07, 4'd2},   // R2 direct-line mask
    '{1'b1, 5'h01, 8'hA5, 8'hA5, 4'd2},   // R2 address whole
    '{1'b1, 5'h02, 8'h30, 8'h30, 4'd2},   // R2 control without go
    '{1'b1, 5'h0C, 8'hFF, 8'h00, 4'd4},   // R4 unmapped write/read
    '{1'b0, 5'h11, 8'h00, 8'h00, 4'd4},   // R4 last window offset
    '{1'b0, 5'h15, 8'h00, 8'h00, 4'd4},   // R4 beyond window
    '{1'b1, 5'h04, 8'hFF, 8'h00, 4'd3},   // R3 status write
    '{1'b0, 5'h03, 8'h00, 8'hDF, 4'd4},   // R4 unmapped write left mode
    '{1'b1, 5'h07, 8'h01, 8'h00, 4'd13},  // R13 soft reset
    '{1'b0, 5'h08, 8'h00, 8'h0F, 4'd13},  // R13 direct back to 0x0F
    '{1'b0, 5'h03, 8'h00, 8'h00, 4'd13},  // R13 mode cleared
    '{1'b0, 5'h02, 8'h00, 8'h00, 4'd13},  // R13 control cleared
    '{1'b1, 5'h07, 8'h06, 8'h06, 4'd2}    // R2 extended control stored
  };

  initial begin
    logic [7:0] r; int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd_chk(1, "status reset", 5'h04, 8'h00);
    rd_chk(1, "ext reset", 5'h05, 8'h00);
    rd_chk(1, "ctrl reset", 5'h02, 8'h00);
    rd_chk(1, "direct reset", 5'h08, 8'h0F);
    rd_chk(1, "mode reset", 5'h03, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].a, VEC[i].wd);
      cpu(1'b0, VEC[i].a, 8'h00, r, w);
      check(int'(VEC[i].req), $sformatf("vector %0d", i), {24'h0, r}, {24'h0, VEC[i].exp});
    end

    // R7 NACK on address
    wr(5'h01, 8'hA4);
    nack_op = OPW; clr_log();
    wr(5'h00, 8'h11);
    check(7, "addr nack commands", sig_now(), seq(1, OPW));
    check(5, "engine address bits 7:1", {25'h0, log_adr[0]}, 32'h52);
    rd_chk(7, "status after addr nack", 5'h04, 8'h04);
    rd_chk(7, "aborted flag", 5'h05, 8'h01);
    wr(5'h05, 8'h01);
    rd_chk(3, "ext cleared by one", 5'h05, 8'h00);
    wr(5'h04, 8'hFF);
    rd_chk(3, "error survives status write", 5'h04, 8'h04);

    // R5 idle write
    nack_op = 7; clr_log();
    wr(5'h00, 8'h3C);
    check(5, "idle write commands", sig_now(), seq(2, OPW, SND));
    check(5, "sent byte", {24'h0, log_dat[1]}, 32'h3C);
    rd_chk(5, "status after acked start", 5'h04, 8'h01);

    // R6 held bus, ack then NACK
    clr_log();
    wr(5'h00, 8'h55);
    check(6, "held write commands", sig_now(), seq(1, SND));
    nack_op = SND; clr_log();
    wr(5'h00, 8'h66);
    check(6, "send nack commands", sig_now(), seq(2, SND, STP));
    rd_chk(6, "status after send nack", 5'h04, 8'h04);
    rd_chk(6, "aborted after send nack", 5'h05, 8'h01);
    nack_op = 7; clr_log();
    wr(5'h00, 8'h67);
    check(6, "bus released after nack", sig_now(), seq(2, OPW, SND));

    // R8 start read while held
    clr_log();
    wr(5'h02, 8'h03);
    check(8, "read start on held bus", sig_now(), seq(2, STP, OPR));
    rd_chk(8, "status read ready", 5'h04, 8'h20);

    // R11 single receive
    clr_log();
    rd_chk(11, "received byte", 5'h00, 8'h9A);
    check(11, "receive commands", sig_now(), seq(1, RCV));
    rd_chk(11, "ready cleared", 5'h04, 8'h00);

    // R10 empty read
    clr_log();
    rd_chk(10, "empty read returns stored byte", 5'h00, 8'h9A);
    check(10, "empty read commands", sig_now(), seq(0));

    // R12 chained reads, pending 2
    wr(5'h02, 8'h23);
    clr_log();
    rd_chk(12, "first chained byte", 5'h00, 8'h9B);
    check(12, "chained commands", sig_now(), seq(3, RCV, STP, OPR));
    rd_chk(12, "pending 2 to 1", 5'h02, 8'h13);
    rd_chk(12, "ready kept", 5'h04, 8'h20);
    clr_log();
    rd_chk(12, "second chained byte", 5'h00, 8'h9C);
    rd_chk(12, "pending 1 to 0", 5'h02, 8'h03);
    clr_log();
    rd_chk(11, "last byte", 5'h00, 8'h9D);
    check(11, "last receive only", sig_now(), seq(1, RCV));

    // R8 NACK on start-read
    nack_op = OPR; clr_log();
    wr(5'h02, 8'h03);
    check(8, "read restart commands", sig_now(), seq(2, STP, OPR));
    rd_chk(8, "status after read nack", 5'h04, 8'h04);
    rd_chk(8, "aborted after read nack", 5'h05, 8'h01);

    // R9 go with write direction
    nack_op = 7;
    wr(5'h00, 8'h42);
    rd_chk(9, "busy before go-write", 5'h04, 8'h01);
    clr_log();
    wr(5'h02, 8'h01);
    check(9, "go-write issues nothing", sig_now(), seq(0));
    rd_chk(9, "busy cleared", 5'h04, 8'h00);

    // R14 engine back-pressure
    stall = 4; stall_seen = 0; stall_bad = 0; clr_log();
    cpu(1'b1, 5'h00, 8'h77, r, w);
    check(14, "stall cycles seen", stall_seen, 4);
    check(14, "cpu ready during stall", stall_bad, 0);
    check(14, "cpu wait covers stall", {31'h0, w >= 6}, 32'h1);
    check(14, "stalled send commands", sig_now(), seq(1, SND));
    check(14, "held command data", {24'h0, log_dat[0]}, 32'h77);
    check(14, "no overlapping commands", overlap, 0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R14 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule